// File: doc/BRIEF.md
# Descriptor-Chained Transmit Queue Engine

This block is the transmit queue engine of one device endpoint. Software places a chain of 16-byte descriptors in memory. Each descriptor names a data buffer, the buffer's length and the address of the following descriptor. Software loads the address of the first descriptor and issues a go command. From then on the engine walks the chain by itself. It reads a descriptor and, if hardware owns it, streams the buffer out one byte at a time. It then hands the descriptor back to software by rewriting its flag word with the ownership bit cleared, and moves on to the next descriptor.

Ownership is how the two sides pass control. When the engine meets a descriptor that software still owns, it waits on that descriptor. A resume command makes it read the same descriptor again. A descriptor with a zero length is never sent: the engine flags a length error and waits on it. A descriptor marked for skipping is handed back without any data being moved. Completion and error events land in write-one-to-clear status registers. Each status register is gated by an enable register onto a single interrupt line.

Top module: `dq_tx_engine`

## Requirements
- R1: After reset the queue is inactive. The current-descriptor register reads 0, both status registers read 0, `irq` is 0, and `mem_req` and `st_valid` are 0.
- R2: Registers are selected by `reg_addr`: 0 control, 1 start address, 2 current descriptor (read only), 3 done status, 4 done enable, 5 error status, 6 error enable. A read returns its data on `reg_rdata` one cycle after `reg_rd`. In the control register, write bit 0 is go, bit 1 is stop and bit 2 is resume; read bit 0 is active. Go copies the start address into the current-descriptor register and makes the queue active. Go is ignored while the queue is active.
- R3: A descriptor at address A is four little-endian words: A+0 flags, A+4 next-descriptor address, A+8 buffer address (low two bits ignored), A+12 length in bits 15:0. In the flag word, bit 0 means hardware owns the descriptor, bit 2 means skip it, and bit 7 means interrupt on completion. Buffer bytes leave in increasing address order on the byte stream, and `st_last` is set on the final byte.
- R4: After the last byte of a buffer is accepted, the engine writes the flag word back with bit 0 cleared and every other bit unchanged. The current-descriptor register then takes the next-descriptor address.
- R5: A descriptor whose flag bit 0 is clear moves no data, is not written back and leaves the current-descriptor register unchanged. The queue stays active. A resume command reads that same descriptor again.
- R6: A descriptor with both bit 0 and bit 2 set sends no byte. It is written back with bit 0 cleared, and the queue advances.
- R7: A hardware-owned descriptor that is not skipped and has length 0 sends no byte and is not written back. It sets bit EP_IDX of the error status register and holds the current-descriptor register. A resume reads it again.
- R8: Completing a descriptor sets bit EP_IDX of the done status register only when flag bit 7 is set.
- R9: Writing a 1 to a bit of a status register clears it. Writing a 0 leaves it unchanged.
- R10: `irq` is high whenever a status bit and its enable bit are both set, and low otherwise.
- R11: Stop takes effect only at a descriptor boundary. A descriptor already in progress completes, including its writeback, before active drops. A queue waiting on a descriptor goes inactive on the cycle after the stop.
- R12: While `st_valid` is high and `st_ready` is low, `st_data` and `st_last` hold. While `mem_req` is high and `mem_ready` is low, the request holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Stream byte valid |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of a buffer |
| st_ready | input | 1 | Stream sink ready |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with EP_IDX set to 5. This places the done and error bits away from bit 0, so a wrong bit position in the status, enable or interrupt path shows up. LEN_W stays at 16, so the length field is the low half of word 3. Lengths of 1, 5, 8 and 40 bytes cover partial final words, exact word multiples and multi-word buffers. Memory and stream back-pressure follow fixed, interleaved patterns, so both stall paths are exercised during fetches, transfers and writebacks.

// File: rtl/dq_tx_pkg.sv
package dq_tx_pkg;
  // flag bit positions inside descriptor word 0
  localparam int FLG_OWN  = 0;
  localparam int FLG_SKIP = 2;
  localparam int FLG_IRQ  = 7;

  // register selects
  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_START  = 3'd1;
  localparam logic [2:0] RA_CUR    = 3'd2;
  localparam logic [2:0] RA_DONE   = 3'd3;
  localparam logic [2:0] RA_DONEEN = 3'd4;
  localparam logic [2:0] RA_ERR    = 3'd5;
  localparam logic [2:0] RA_ERREN  = 3'd6;

  // control write bits
  localparam int CB_GO     = 0;
  localparam int CB_HALT   = 1;
  localparam int CB_RESUME = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_DECIDE, S_STALL,
    S_DREQ, S_DWAIT, S_DRAIN, S_WB
  } seq_state_t;
endpackage

// File: rtl/dq_tx_regs.sv
module dq_tx_regs
  import dq_tx_pkg::*;
#(
  parameter int EP_IDX = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_go,
  output logic        cmd_halt,
  output logic        cmd_resume,
  output logic [31:0] start_addr,
  input  logic        active,
  input  logic [31:0] cur_addr,
  input  logic        done_evt,
  input  logic        err_evt,
  output logic        irq
);
  logic done_q, err_q, done_en, err_en, irq_q;
  logic ctrl_wr, done_clr, err_clr;

  always_comb begin
    ctrl_wr    = reg_wr && (reg_addr == RA_CTRL);
    cmd_go     = ctrl_wr && reg_wdata[CB_GO];
    cmd_halt   = ctrl_wr && reg_wdata[CB_HALT];
    cmd_resume = ctrl_wr && reg_wdata[CB_RESUME];
    done_clr   = reg_wr && (reg_addr == RA_DONE) && reg_wdata[EP_IDX];
    err_clr    = reg_wr && (reg_addr == RA_ERR) && reg_wdata[EP_IDX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      done_en    <= 1'b0;
      err_en     <= 1'b0;
      irq_q      <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (reg_wr && reg_addr == RA_START)  start_addr <= reg_wdata;
      if (reg_wr && reg_addr == RA_DONEEN) done_en <= reg_wdata[EP_IDX];
      if (reg_wr && reg_addr == RA_ERREN)  err_en  <= reg_wdata[EP_IDX];
      // a new event wins over a clear in the same cycle
      done_q <= done_evt | (done_q & ~done_clr);
      err_q  <= err_evt  | (err_q  & ~err_clr);
      irq_q  <= (done_q & done_en) | (err_q & err_en);
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL:   reg_rdata <= {31'd0, active};
          RA_START:  reg_rdata <= start_addr;
          RA_CUR:    reg_rdata <= cur_addr;
          RA_DONE:   reg_rdata <= 32'(done_q) << EP_IDX;
          RA_DONEEN: reg_rdata <= 32'(done_en) << EP_IDX;
          RA_ERR:    reg_rdata <= 32'(err_q) << EP_IDX;
          RA_ERREN:  reg_rdata <= 32'(err_en) << EP_IDX;
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

  assign irq = irq_q;

  // R9: a status bit with no event and no clear keeps its value
  w1c_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done_evt && !done_clr) |=> $stable(done_q));
endmodule

// File: rtl/dq_tx_unpack.sv
module dq_tx_unpack (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  cnt,
  input  logic        last,
  output logic        busy,
  output logic        st_valid,
  output logic [7:0]  st_data,
  output logic        st_last,
  input  logic        st_ready
);
  logic [23:0] sh;
  logic [1:0]  left;
  logic        last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      left     <= '0;
      last_q   <= 1'b0;
      st_valid <= 1'b0;
      st_data  <= '0;
      st_last  <= 1'b0;
    end else if (load && !st_valid) begin
      st_valid <= 1'b1;
      st_data  <= word[7:0];
      sh       <= word[31:8];
      left     <= 2'(cnt - 3'd1);
      last_q   <= last;
      st_last  <= last && (cnt == 3'd1);
    end else if (st_valid && st_ready) begin
      if (left != 2'd0) begin
        st_data <= sh[7:0];
        sh      <= {8'd0, sh[23:8]};
        left    <= left - 2'd1;
        st_last <= last_q && (left == 2'd1);
      end else begin
        st_valid <= 1'b0;
        st_last  <= 1'b0;
      end
    end
  end

  assign busy = st_valid;

  // R12: stream byte holds under back-pressure
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));
endmodule

// File: rtl/dq_tx_seq.sv
module dq_tx_seq
  import dq_tx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_go,
  input  logic        cmd_halt,
  input  logic        cmd_resume,
  input  logic [31:0] start_addr,
  output logic        active,
  output logic [31:0] cur_addr,
  output logic        done_evt,
  output logic        err_evt,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        pk_load,
  output logic [31:0] pk_word,
  output logic [2:0]  pk_cnt,
  output logic        pk_last,
  input  logic        pk_busy
);
  seq_state_t      state;
  logic [1:0]      fidx;
  logic [31:0]     cur, w0, nxt, bufp;
  logic [LEN_W-1:0] rem;
  logic            halt_pend;
  logic [2:0]      take;

  always_comb begin
    take      = (rem >= LEN_W'(4)) ? 3'd4 : 3'(rem);
    mem_req   = (state == S_FREQ) || (state == S_WB) ||
                ((state == S_DREQ) && !pk_busy);
    mem_we    = (state == S_WB);
    mem_wdata = w0 & ~(32'd1 << FLG_OWN);
    case (state)
      S_FREQ:  mem_addr = cur + {28'd0, fidx, 2'b00};
      S_DREQ:  mem_addr = bufp;
      default: mem_addr = cur;
    endcase
    pk_load  = (state == S_DWAIT) && mem_rvalid;
    pk_word  = mem_rdata;
    pk_cnt   = take;
    pk_last  = (rem <= LEN_W'(4));
    done_evt = (state == S_WB) && mem_ready && w0[FLG_IRQ];
    err_evt  = (state == S_DECIDE) && !w0[FLG_SKIP] && (rem == '0);
    active   = (state != S_IDLE);
    cur_addr = cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      fidx      <= '0;
      cur       <= '0;
      w0        <= '0;
      nxt       <= '0;
      bufp      <= '0;
      rem       <= '0;
      halt_pend <= 1'b0;
    end else begin
      if (state == S_IDLE)  halt_pend <= 1'b0;
      else if (cmd_halt)    halt_pend <= 1'b1;
      case (state)
        S_IDLE: if (cmd_go) begin
          cur   <= start_addr;
          fidx  <= '0;
          state <= S_FREQ;
        end
        S_FREQ: if (mem_ready) state <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          case (fidx)
            2'd0: w0 <= mem_rdata;
            2'd1: nxt <= mem_rdata;
            2'd2: bufp <= {mem_rdata[31:2], 2'b00};
            default: rem <= mem_rdata[LEN_W-1:0];
          endcase
          if (fidx == 2'd0 && !mem_rdata[FLG_OWN]) state <= S_STALL;
          else if (fidx == 2'd3)                   state <= S_DECIDE;
          else begin
            fidx  <= fidx + 2'd1;
            state <= S_FREQ;
          end
        end
        S_DECIDE: begin
          if (w0[FLG_SKIP])   state <= S_WB;
          else if (rem == '0) state <= S_STALL;
          else                state <= S_DREQ;
        end
        S_STALL: begin
          if (cmd_halt || halt_pend) state <= S_IDLE;
          else if (cmd_resume) begin
            fidx  <= '0;
            state <= S_FREQ;
          end
        end
        S_DREQ: if (!pk_busy && mem_ready) state <= S_DWAIT;
        S_DWAIT: if (mem_rvalid) begin
          rem  <= rem - LEN_W'(take);
          bufp <= bufp + 32'd4;
          state <= (rem <= LEN_W'(4)) ? S_DRAIN : S_DREQ;
        end
        S_DRAIN: if (!pk_busy) state <= S_WB;
        S_WB: if (mem_ready) begin
          cur  <= nxt;
          fidx <= '0;
          state <= (halt_pend || cmd_halt) ? S_IDLE : S_FREQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: a memory request holds until accepted
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5: while waiting with no command the current descriptor does not move
  stall_cur_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_STALL && !cmd_resume && !cmd_halt) |=> $stable(cur));
endmodule

// File: rtl/dq_tx_engine.sv
module dq_tx_engine #(
  parameter int EP_IDX = 0,
  parameter int LEN_W  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        st_valid,
  output logic [7:0]  st_data,
  output logic        st_last,
  input  logic        st_ready,
  output logic        irq
);
  logic        cmd_go, cmd_halt, cmd_resume, active, done_evt, err_evt;
  logic [31:0] start_addr, cur_addr, pk_word;
  logic        pk_load, pk_last, pk_busy;
  logic [2:0]  pk_cnt;

  dq_tx_regs #(.EP_IDX(EP_IDX)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_go(cmd_go), .cmd_halt(cmd_halt), .cmd_resume(cmd_resume),
    .start_addr(start_addr), .active(active), .cur_addr(cur_addr),
    .done_evt(done_evt), .err_evt(err_evt), .irq(irq)
  );

  dq_tx_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_halt(cmd_halt),
    .cmd_resume(cmd_resume), .start_addr(start_addr), .active(active),
    .cur_addr(cur_addr), .done_evt(done_evt), .err_evt(err_evt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .pk_load(pk_load), .pk_word(pk_word),
    .pk_cnt(pk_cnt), .pk_last(pk_last), .pk_busy(pk_busy)
  );

  dq_tx_unpack u_unpack (
    .clk(clk), .rst(rst), .load(pk_load), .word(pk_word), .cnt(pk_cnt),
    .last(pk_last), .busy(pk_busy), .st_valid(st_valid), .st_data(st_data),
    .st_last(st_last), .st_ready(st_ready)
  );

  // R11: an inactive queue never has a byte on the stream
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> !st_valid);

  // R7: a length error is flagged with no byte in flight
  lenerr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_evt |-> !st_valid);
endmodule

// File: tb/dq_tx_engine_tb.sv
`timescale 1ns/1ps
module dq_tx_engine_tb;
  localparam int EP = 5;
  localparam logic [31:0] EPB = 32'd1 << EP;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        st_valid, st_last, st_ready = 1'b0, irq;
  logic [7:0]  st_data;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mem [0:255];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_a = '0;
  logic [31:0] tb_d = '0;
  logic [8:0]  exp_q [$];

  always #2.5 clk = ~clk;

  dq_tx_engine #(.EP_IDX(EP), .LEN_W(16)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last),
    .st_ready(st_ready), .irq(irq)
  );

  // memory model with back-pressure and one-cycle read latency
  always @(posedge clk) begin
    cyc        <= cyc + 1;
    mem_ready  <= (cyc % 3) != 1;
    st_ready   <= (cyc % 5) != 2;
    mem_rvalid <= 1'b0;
    if (tb_we) mem[tb_a] <= tb_d;
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:2]];
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 100000) begin
    total++; bad++;
    $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, 100000);
    finish_run();
  end

  // per-cycle reference comparison of the byte stream (R3, R12)
  always @(negedge clk) if (!rst && st_valid && st_ready) begin
    total++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL R3 unexpected byte act=%h/%b exp=none", st_data, st_last);
    end else begin
      logic [8:0] e;
      e = exp_q.pop_front();
      if ({st_last, st_data} !== e) begin
        bad++;
        $display("FAIL R3 stream byte act=%h/%b exp=%h/%b", st_data, st_last, e[7:0], e[8]);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_a = byte_addr[9:2]; tb_d = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic mk_desc(input logic [31:0] a, input logic [31:0] flg,
                         input logic [31:0] nx, input logic [31:0] bf, input int len);
    poke(a, flg); poke(a + 4, nx); poke(a + 8, bf); poke(a + 12, 32'(len));
  endtask

  task automatic fill(input logic [31:0] bf, input int len, input int seed, input bit expect_out);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) begin
        int i = w * 4 + b;
        logic [7:0] v = 8'((seed + i * 7) & 255);
        word[8*b +: 8] = v;
        if (expect_out && i < len) exp_q.push_back({i == len - 1, v});
      end
      poke(bf + 32'(w * 4), word);
    end
  endtask

  task automatic settle(); repeat (400) @(posedge clk); endtask

  logic [31:0] r;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 mem_req", {31'd0, mem_req}, 0);
    check("R1 st_valid", {31'd0, st_valid}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(3'd0, r); check("R1 active", r, 0);
    rd(3'd2, r); check("R1 cur", r, 0);
    rd(3'd3, r); check("R1 done", r, 0);
    rd(3'd5, r); check("R1 err", r, 0);

    wr(3'd4, EPB);
    // chain: lengths 5, 1, 8, then a software-owned descriptor
    mk_desc(32'h00, 32'h81, 32'h10, 32'h200, 5); fill(32'h200, 5, 3, 1);
    mk_desc(32'h10, 32'h01, 32'h20, 32'h240, 1); fill(32'h240, 1, 40, 1);
    mk_desc(32'h20, 32'h81, 32'h30, 32'h280, 8); fill(32'h280, 8, 90, 1);
    mk_desc(32'h30, 32'h00, 32'h40, 32'h300, 3);
    wr(3'd1, 32'h00); wr(3'd0, 32'h1);
    settle();
    check("R3 all bytes sent", 32'(exp_q.size()), 0);
    check("R4 wb desc0", mem[0], 32'h80);
    check("R4 wb desc1", mem[4], 32'h00);
    check("R4 wb desc2", mem[8], 32'h80);
    rd(3'd2, r); check("R5 cur on sw-owned", r, 32'h30);
    rd(3'd0, r); check("R5 still active", r, 1);
    rd(3'd3, r); check("R8 done bit", r, EPB);
    check("R10 irq done", {31'd0, irq}, 1);

    // R2: go ignored while active
    wr(3'd1, 32'h40); wr(3'd0, 32'h1); settle();
    rd(3'd2, r); check("R2 go ignored when active", r, 32'h30);

    // R5: resume with descriptor still software-owned
    wr(3'd0, 32'h4); settle();
    rd(3'd2, r); check("R5 resume refetch sw-owned", r, 32'h30);

    // R9 clear, R8 no-IOC descriptor
    wr(3'd3, EPB);
    rd(3'd3, r); check("R9 w1c clears", r, 0);
    mk_desc(32'h30, 32'h01, 32'h40, 32'h300, 3); fill(32'h300, 3, 17, 1);
    wr(3'd0, 32'h4); settle();
    check("R5 resume sends", 32'(exp_q.size()), 0);
    rd(3'd2, r); check("R4 cur advance", r, 32'h40);
    rd(3'd3, r); check("R8 no done without flag", r, 0);
    check("R10 irq low", {31'd0, irq}, 0);

    // R6 skip descriptor
    mk_desc(32'h40, 32'h85, 32'h50, 32'h380, 4); fill(32'h380, 4, 55, 0);
    wr(3'd0, 32'h4); settle();
    check("R6 skip wb", mem[16], 32'h84);
    rd(3'd2, r); check("R6 cur after skip", r, 32'h50);
    rd(3'd3, r); check("R8 done on skip", r, EPB);
    wr(3'd3, 32'h0);
    rd(3'd3, r); check("R9 write zero keeps", r, EPB);
    wr(3'd3, EPB);

    // R7 zero length
    wr(3'd6, 32'h0);
    mk_desc(32'h50, 32'h81, 32'h60, 32'h3C0, 0);
    wr(3'd0, 32'h4); settle();
    rd(3'd5, r); check("R7 err bit", r, EPB);
    rd(3'd2, r); check("R7 cur holds", r, 32'h50);
    check("R7 no writeback", mem[20], 32'h81);
    check("R10 irq masked", {31'd0, irq}, 0);
    wr(3'd6, EPB); repeat (3) @(posedge clk); @(negedge clk);
    check("R10 irq err", {31'd0, irq}, 1);
    wr(3'd5, EPB); repeat (3) @(posedge clk); @(negedge clk);
    check("R10 irq cleared", {31'd0, irq}, 0);
    poke(32'h5C, 32'd2); fill(32'h3C0, 2, 77, 1);
    wr(3'd0, 32'h4); settle();
    check("R7 recovered sends", 32'(exp_q.size()), 0);
    rd(3'd2, r); check("R7 cur after recover", r, 32'h60);

    // R11 stop while waiting
    wr(3'd0, 32'h2);
    rd(3'd0, r); check("R11 stop at wait", r, 0);

    // R11 stop mid-transfer
    mk_desc(32'h60, 32'h01, 32'h70, 32'h200, 40); fill(32'h200, 40, 11, 1);
    mk_desc(32'h70, 32'h01, 32'h80, 32'h240, 2);
    wr(3'd1, 32'h60); wr(3'd0, 32'h1);
    repeat (12) @(posedge clk);
    wr(3'd0, 32'h2); settle();
    check("R11 descriptor finished", 32'(exp_q.size()), 0);
    check("R11 wb before stop", mem[24], 32'h00);
    check("R11 next untouched", mem[28], 32'h01);
    rd(3'd2, r); check("R11 cur at next", r, 32'h70);
    rd(3'd0, r); check("R11 inactive", r, 0);

    finish_run();
  end
endmodule